// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This controller powers up and powers down a two-port USB 2.0 PHY. An init request for one port starts a fixed chain of steps. The reference clock is turned on first. After a wait, the shared power-on reset is released. After a second wait, a single configuration write turns on the PHY clock: data 0x04, which sets bit 2, goes to register address 0x06 of port 0. The controller then waits for the PHY clock to settle, releases the requesting port's UTMI reset, waits again and reports completion.

An exit request undoes the bring-up in the opposite order. It puts the port's UTMI reset back, then the power-on reset, then stops the reference clock. It takes one cycle per step.

Every wait is counted in system clock cycles, derived from the `CLK_HZ` parameter:

| Wait | Time | Cycles |
|------|------|--------|
| `REF_CYC` | 100 us | CLK_HZ/10000 |
| `POR_CYC` | 300 us | 3·CLK_HZ/10000 |
| `SET_CYC` | 2 ms | CLK_HZ/500 |

The configuration write is handed to a separate test-register bridge through a request/acknowledge pair.

Top module: `usb_phy_powerup_seq`

## Requirements
- R1: After reset, `ref_clk_en`=0, `por_rst_n`=0, `utmi_rst_n`=2'b00, `busy`=0, `done`=0 and `wr_req`=0. All resets are active-low.
- R2: When the sequencer is idle, the clock edge that samples `init_req`=1 also sets `ref_clk_en` and `busy`. The port number is taken from `req_port` on that same edge.
- R3: `por_rst_n` rises exactly REF_CYC = CLK_HZ/10000 cycles after `ref_clk_en` rises. `por_rst_n` is never high while `ref_clk_en` is low.
- R4: `wr_req` rises exactly POR_CYC = 3·CLK_HZ/10000 cycles after `por_rst_n` rises. While `wr_req` is high, `wr_port`=0, `wr_addr`=8'h06 and `wr_data`=8'h04.
- R5: `wr_req` stays high until `wr_ack` is sampled high. It falls on the edge that samples `wr_ack`.
- R6: `utmi_rst_n[req_port]` rises exactly SET_CYC = CLK_HZ/500 cycles after the edge that sampled `wr_ack`. The other port's bit stays unchanged.
- R7: `done` pulses high for one cycle exactly SET_CYC cycles after the UTMI reset release. `busy` falls on the same edge.
- R8: When the sequencer is idle, the edge that samples `exit_req`=1 drives `utmi_rst_n[req_port]` low. The next edge drives `por_rst_n` low. The edge after that drives `ref_clk_en` low and pulses `done`.
- R9: An `init_req` or `exit_req` that arrives while `busy` is high is ignored. It changes neither the timing of the running sequence nor the UTMI reset of any other port.
- R10: When the sequencer is idle and `init_req` and `exit_req` are sampled high together, the init sequence runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the power-up sequence |
| exit_req | input | 1 | Start the power-down sequence |
| req_port | input | 1 | Port the request is for |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| ref_clk_en | output | 1 | Reference clock enable |
| por_rst_n | output | 1 | Shared power-on reset, active-low |
| utmi_rst_n | output | 2 | Per-port UTMI reset, active-low |
| wr_req | output | 1 | Configuration write request to the bridge |
| wr_port | output | 1 | Target port of the write |
| wr_addr | output | 8 | Target register address |
| wr_data | output | 8 | Write data |
| wr_ack | input | 1 | Bridge accepted the write |

## Verification
A wrong state or a bad counter load shows at the ports as a reset or clock edge that comes too early or too late. The bench measures every gap to the exact cycle, so such a fault shows up at the very next transition. A stray transition taken from busy states would let an ignored request disturb the other port's UTMI reset or end the run early. The bench checks this when that bit is read back, and when `done` arrives, within the same sequence. A broken handshake hold shows within the cycles the bench randomly delays `wr_ack`.

// File: rtl/usb_phy_powerup_seq.sv
module usb_phy_powerup_seq #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       exit_req,
  input  logic       req_port,
  output logic       busy,
  output logic       done,
  output logic       ref_clk_en,
  output logic       por_rst_n,
  output logic [1:0] utmi_rst_n,
  output logic       wr_req,
  output logic       wr_port,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  input  logic       wr_ack
);
  localparam int unsigned REF_CYC = (CLK_HZ / 10000 > 0) ? CLK_HZ / 10000 : 1;
  localparam int unsigned POR_CYC = (3 * (CLK_HZ / 10000) > 0) ? 3 * (CLK_HZ / 10000) : 1;
  localparam int unsigned SET_CYC = (CLK_HZ / 500 > 0) ? CLK_HZ / 500 : 1;
  localparam int CW = $clog2(SET_CYC + POR_CYC + REF_CYC + 1);

  typedef enum logic [2:0] {IDLE, W_REF, W_POR, WR, W_CLK, W_UTMI, X_POR, X_CLK} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          port;

  wire tick = (cnt == '0);

  assign busy    = (st != IDLE);
  assign wr_port = 1'b0;
  assign wr_addr = 8'h06;
  assign wr_data = 8'h04;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      port       <= 1'b0;
      done       <= 1'b0;
      ref_clk_en <= 1'b0;
      por_rst_n  <= 1'b0;
      utmi_rst_n <= 2'b00;
      wr_req     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      case (st)
        IDLE: begin
          if (init_req) begin
            port       <= req_port;
            ref_clk_en <= 1'b1;
            cnt        <= CW'(REF_CYC - 1);
            st         <= W_REF;
          end else if (exit_req) begin
            port                 <= req_port;
            utmi_rst_n[req_port] <= 1'b0;
            st                   <= X_POR;
          end
        end
        W_REF: if (tick) begin
          por_rst_n <= 1'b1;
          cnt       <= CW'(POR_CYC - 1);
          st        <= W_POR;
        end
        W_POR: if (tick) begin
          wr_req <= 1'b1;
          st     <= WR;
        end
        WR: if (wr_ack) begin
          wr_req <= 1'b0;
          cnt    <= CW'(SET_CYC - 1);
          st     <= W_CLK;
        end
        W_CLK: if (tick) begin
          utmi_rst_n[port] <= 1'b1;
          cnt              <= CW'(SET_CYC - 1);
          st               <= W_UTMI;
        end
        W_UTMI: if (tick) begin
          done <= 1'b1;
          st   <= IDLE;
        end
        X_POR: begin
          por_rst_n <= 1'b0;
          st        <= X_CLK;
        end
        X_CLK: begin
          ref_clk_en <= 1'b0;
          done       <= 1'b1;
          st         <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_phy_powerup_seq_chk.sv
module usb_phy_powerup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       ref_clk_en,
  input logic       por_rst_n,
  input logic [1:0] utmi_rst_n,
  input logic       wr_req,
  input logic       wr_ack
);
  // R3
  por_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_rst_n |-> ref_clk_en);

  // R4
  wr_when_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (por_rst_n && ref_clk_en && busy));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req);

  // R6
  utmi0_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(utmi_rst_n[0]) |-> por_rst_n);

  // R6
  utmi1_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(utmi_rst_n[1]) |-> por_rst_n);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  clk_off_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_clk_en) |-> (!por_rst_n && done));
endmodule

bind usb_phy_powerup_seq usb_phy_powerup_seq_chk u_chk (.*);

// File: tb/tb_usb_phy_powerup_seq.sv
module tb_usb_phy_powerup_seq;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int REF = CLK_HZ / 10000;
  localparam int POR = 3 * (CLK_HZ / 10000);
  localparam int SET = CLK_HZ / 500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_req = 1'b0, exit_req = 1'b0, req_port = 1'b0, wr_ack = 1'b0;
  logic busy, done, ref_clk_en, por_rst_n, wr_req, wr_port;
  logic [1:0] utmi_rst_n;
  logic [7:0] wr_addr, wr_data;
  int cyc = 0, checks = 0, fails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_phy_powerup_seq #(.CLK_HZ(CLK_HZ)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap(input int a, input int b);
    return b - a;
  endfunction

  task automatic do_init(input bit p, input int ackdly, input bit inject, input bit both);
    int e0, t1, t2, ta, t3, t4;
    @(negedge clk);
    init_req = 1'b1; exit_req = both; req_port = p; e0 = cyc + 1;
    @(negedge clk);
    init_req = 1'b0; exit_req = 1'b0;
    chk(ref_clk_en && busy, both ? "R10" : "R2", {ref_clk_en, busy}, 3);
    chk(utmi_rst_n == 2'b00, "R10", utmi_rst_n, 0);
    while (!por_rst_n) @(negedge clk);
    t1 = cyc;
    chk(gap(e0, t1) == REF, "R3", gap(e0, t1), REF);
    if (inject) begin
      repeat (3) @(negedge clk);
      init_req = 1'b1; exit_req = 1'b1; req_port = ~p;
      @(negedge clk);
      init_req = 1'b0; exit_req = 1'b0;
    end
    while (!wr_req) @(negedge clk);
    t2 = cyc;
    chk(gap(t1, t2) == POR, inject ? "R9" : "R4", gap(t1, t2), POR);
    chk(!wr_port && wr_addr == 8'h06 && wr_data == 8'h04, "R4", {wr_port, wr_addr, wr_data}, 17'h00604);
    for (int i = 0; i < ackdly; i++) begin
      @(negedge clk);
      chk(wr_req, "R5", wr_req, 1);
    end
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
    ta = cyc;
    chk(!wr_req, "R5", wr_req, 0);
    while (!utmi_rst_n[p]) @(negedge clk);
    t3 = cyc;
    chk(gap(ta, t3) == SET, "R6", gap(ta, t3), SET);
    chk(utmi_rst_n[~p] == 1'b0, inject ? "R9" : "R6", utmi_rst_n[~p], 0);
    while (!done) @(negedge clk);
    t4 = cyc;
    chk(gap(t3, t4) == SET, "R7", gap(t3, t4), SET);
    chk(!busy, "R7", busy, 0);
    @(negedge clk);
    chk(!done, "R7", done, 0);
  endtask

  task automatic do_exit(input bit p);
    @(negedge clk);
    exit_req = 1'b1; req_port = p;
    @(negedge clk);
    exit_req = 1'b0;
    chk(utmi_rst_n[p] == 1'b0 && por_rst_n && ref_clk_en && busy, "R8",
        {utmi_rst_n[p], por_rst_n, ref_clk_en, busy}, 7);
    @(negedge clk);
    chk(!por_rst_n && ref_clk_en, "R8", {por_rst_n, ref_clk_en}, 1);
    @(negedge clk);
    chk(!ref_clk_en && done && !busy, "R8", {ref_clk_en, done, busy}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(!ref_clk_en && !por_rst_n && utmi_rst_n == 2'b00 && !busy && !done && !wr_req,
        "R1", {ref_clk_en, por_rst_n, utmi_rst_n, busy, done, wr_req}, 0);
    rst_n = 1'b1;
    do_init(1'b0, 0, 1'b0, 1'b0);
    do_exit(1'b0);
    do_init(1'b1, 5, 1'b1, 1'b0);
    do_exit(1'b1);
    do_init(1'b0, 2, 1'b0, 1'b1);
    do_exit(1'b0);
    for (int k = 0; k < 6; k++) begin
      bit p;
      p = 1'($urandom_range(0, 1));
      do_init(p, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'b0);
      do_exit(p);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule